// File: doc/BRIEF.md
# SDRAM Open-Page Bank Tracker

This block sits in front of the command sequencer of an SDRAM controller. It keeps the open page of every chip-select region and, for each read or write request, decides which commands must come before the data access. Each region holds a single open row, which all four internal banks of the device share, plus one active bit per bank. A request can need a precharge of all banks followed by an activate, an activate alone, or nothing before the access.

A request is taken when `req_valid` and `req_ready` are both high. The decision is registered and shown on the `plan_*` outputs one cycle later. It stays there until the sequencer raises `plan_ready`. The page state of the addressed region changes only when the plan is accepted. A pulse on `refresh_start` closes every bank in every region at once. Only one plan is outstanding at a time.

Top module: `sdram_page_tracker`

## Requirements
- R1: After reset `plan_valid` is 0, `req_ready` is 1 and no bank is active in any region, so the first request to any region yields kind 1 (activate only).
- R2: `req_ready` is high exactly when no plan is pending. A request taken at a rising edge appears on `plan_valid` with its chip select, bank, row and write flag at the next edge. A `req_valid` pulse while a plan is pending is ignored.
- R3: While `plan_valid` is high and `plan_ready` is low, with no refresh, the plan outputs hold their values.
- R4: A request whose row differs from the open row of its region, with at least one bank of that region active, yields kind 2 (precharge-all, then activate).
- R5: A request to the open row of a region, in a bank that is not active, yields kind 1 (activate only).
- R6: A request to the open row, in a bank that is already active, yields kind 0 (access at once).
- R7: Accepting a kind-1 plan marks only the addressed bank active, records the row and leaves the other bank bits of that region as they were.
- R8: Accepting a kind-2 plan clears every bank bit of that region, records the new row and sets only the addressed bank.
- R9: `refresh_start` clears every bank bit in every region. A plan pending during the refresh, or taken in the same cycle, is turned into kind 1.
- R10: Regions are independent: accepting a plan for one chip select leaves the page state of the others unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Tracker can take a request |
| req_cs | input | CS_W | Chip-select region of the request |
| req_bank | input | BANK_W | Internal bank of the request |
| req_row | input | ROW_W | Row address of the request |
| req_write | input | 1 | 1 = write, 0 = read |
| refresh_start | input | 1 | Refresh begins; closes all pages |
| plan_valid | output | 1 | Command plan pending |
| plan_ready | input | 1 | Sequencer accepts the plan |
| plan_kind | output | 2 | 0 access, 1 activate, 2 precharge-all then activate |
| plan_cs | output | CS_W | Chip select of the plan |
| plan_bank | output | BANK_W | Bank of the plan |
| plan_row | output | ROW_W | Row of the plan |
| plan_write | output | 1 | Write flag of the plan |

## Verification
The bench opens a row, activates a second bank on it, and then checks that the first bank still gives an immediate access. A design whose activate cleared the other bank bits would ask for an activate there instead. After a row miss it checks that a bank active before the miss now needs an activate again, which catches a precharge that leaves stale bits behind. It runs a refresh with a plan held pending and checks that the plan turns into an activate and that no region reports an open row afterwards; a design that ignored refresh would still return accesses or precharges. It also interleaves two chip selects to show that the open row of one region is not overwritten by the other.

// File: rtl/sdram_pt_pkg.sv
// Package: shared types for the SDRAM open-page tracker.
// Assumes the plan encoding below is decoded by the command sequencer.
package sdram_pt_pkg;
    typedef enum logic [1:0] {
        PLAN_ACCESS  = 2'd0,
        PLAN_ACT     = 2'd1,
        PLAN_PRE_ACT = 2'd2
    } plan_kind_t;
endpackage

// File: rtl/pt_region_state.sv
// Module: page state of one chip-select region (open row + bank active bits).
// Assumes refresh has priority over a plan update in the same cycle.
module pt_region_state #(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refresh_i,
    input  logic              upd_i,
    input  logic              clear_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    output logic [BANKS-1:0]  act_o,
    output logic [ROW_W-1:0]  row_o
);
    logic [BANKS-1:0] bank_hot;

    // Decode the addressed bank into a one-hot mask.
    always_comb begin
        bank_hot = '0;
        bank_hot[bank_i] = 1'b1;
    end

    // Track active banks and the open row of this region.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_o <= '0;
            row_o <= '0;
        end else if (refresh_i) begin
            act_o <= '0;
        end else if (upd_i) begin
            act_o <= clear_i ? bank_hot : (act_o | bank_hot);
            row_o <= row_i;
        end
    end

    p_refresh_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_i |=> (act_o == '0));
    p_update_sets_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && !refresh_i) |=> act_o[$past(bank_i)]);
    p_precharge_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_i && clear_i && !refresh_i) |=> ($countones(act_o) == 1));
endmodule

// File: rtl/pt_decide.sv
// Module: combinational command-plan decision for one request.
// Assumes a region with no active bank has no open page.
module pt_decide
    import sdram_pt_pkg::*;
#(
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic [BANKS-1:0]  act_i,
    input  logic [ROW_W-1:0]  open_row_i,
    input  logic [BANK_W-1:0] bank_i,
    input  logic [ROW_W-1:0]  row_i,
    input  logic              force_act_i,
    output plan_kind_t        kind_o
);
    logic page_open;
    logic row_hit;

    // Classify the request against the region's open page.
    always_comb begin
        page_open = |act_i;
        row_hit   = (open_row_i == row_i);
        if (force_act_i || !page_open)
            kind_o = PLAN_ACT;
        else if (!row_hit)
            kind_o = PLAN_PRE_ACT;
        else if (!act_i[bank_i])
            kind_o = PLAN_ACT;
        else
            kind_o = PLAN_ACCESS;
    end
endmodule

// File: rtl/sdram_page_tracker.sv
// Module: open-page tracker for all chip-select regions; registers one plan
// at a time and applies it to the page state when the sequencer accepts it.
// Assumes refresh_start is a single-cycle pulse from the refresh scheduler.
module sdram_page_tracker
    import sdram_pt_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int BANKS  = 4,
    parameter int ROW_W  = 13,
    localparam int CS_W   = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int BANK_W = $clog2(BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [CS_W-1:0]   req_cs,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic              req_write,
    input  logic              refresh_start,
    output logic              plan_valid,
    input  logic              plan_ready,
    output logic [1:0]        plan_kind,
    output logic [CS_W-1:0]   plan_cs,
    output logic [BANK_W-1:0] plan_bank,
    output logic [ROW_W-1:0]  plan_row,
    output logic              plan_write
);
    logic [NUM_CS-1:0][BANKS-1:0] act_all;
    logic [NUM_CS-1:0][ROW_W-1:0] row_all;
    plan_kind_t                   dec_kind;
    logic                         accept;
    logic                         take;

    assign req_ready = !plan_valid;
    assign accept    = plan_valid && plan_ready;
    assign take      = req_valid && req_ready;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_region
        pt_region_state #(.BANKS(BANKS), .ROW_W(ROW_W)) u_state (
            .clk       (clk),
            .rst_n     (rst_n),
            .refresh_i (refresh_start),
            .upd_i     (accept && (plan_cs == CS_W'(g))),
            .clear_i   (plan_kind == PLAN_PRE_ACT),
            .bank_i    (plan_bank),
            .row_i     (plan_row),
            .act_o     (act_all[g]),
            .row_o     (row_all[g])
        );
    end

    pt_decide #(.BANKS(BANKS), .ROW_W(ROW_W)) u_decide (
        .act_i       (act_all[req_cs]),
        .open_row_i  (row_all[req_cs]),
        .bank_i      (req_bank),
        .row_i       (req_row),
        .force_act_i (refresh_start),
        .kind_o      (dec_kind)
    );

    // Register a new plan, retire an accepted one, demote a pending one on refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            plan_valid <= 1'b0;
            plan_kind  <= PLAN_ACCESS;
            plan_cs    <= '0;
            plan_bank  <= '0;
            plan_row   <= '0;
            plan_write <= 1'b0;
        end else if (take) begin
            plan_valid <= 1'b1;
            plan_kind  <= dec_kind;
            plan_cs    <= req_cs;
            plan_bank  <= req_bank;
            plan_row   <= req_row;
            plan_write <= req_write;
        end else begin
            if (accept)
                plan_valid <= 1'b0;
            else if (refresh_start && plan_valid)
                plan_kind <= PLAN_ACT;
        end
    end

    p_take_shows_plan_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> plan_valid);
    p_plan_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && !plan_ready && !refresh_start) |=>
            (plan_valid && $stable(plan_kind) && $stable(plan_row) && $stable(plan_bank)));
    p_access_on_open_bank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (plan_valid && plan_kind == PLAN_ACCESS) |->
            (act_all[plan_cs][plan_bank] && row_all[plan_cs] == plan_row));
    p_refresh_demotes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (refresh_start && (plan_valid || take) && !accept) |=> (plan_kind == PLAN_ACT));
endmodule

// File: tb/sdram_page_tracker_bench.sv
module sdram_page_tracker_bench;
    localparam int NUM_CS = 4;
    localparam int BANKS  = 4;
    localparam int ROW_W  = 13;
    localparam int CS_W   = 2;
    localparam int BANK_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [CS_W-1:0]   req_cs = '0;
    logic [BANK_W-1:0] req_bank = '0;
    logic [ROW_W-1:0]  req_row = '0;
    logic              req_write = 1'b0;
    logic              refresh_start = 1'b0;
    logic              plan_valid;
    logic              plan_ready = 1'b0;
    logic [1:0]        plan_kind;
    logic [CS_W-1:0]   plan_cs;
    logic [BANK_W-1:0] plan_bank;
    logic [ROW_W-1:0]  plan_row;
    logic              plan_write;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    sdram_page_tracker #(.NUM_CS(NUM_CS), .BANKS(BANKS), .ROW_W(ROW_W)) u_sdram_page_tracker (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cs(req_cs), .req_bank(req_bank), .req_row(req_row), .req_write(req_write),
        .refresh_start(refresh_start), .plan_valid(plan_valid), .plan_ready(plan_ready),
        .plan_kind(plan_kind), .plan_cs(plan_cs), .plan_bank(plan_bank),
        .plan_row(plan_row), .plan_write(plan_write)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic issue(input int cs, input int bank, input int row, input bit wr);
        @(negedge clk);
        req_cs = cs[CS_W-1:0]; req_bank = bank[BANK_W-1:0];
        req_row = row[ROW_W-1:0]; req_write = wr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_plan(input int kind, input int cs, input int bank, input int row,
                               input bit wr, input string tag);
        check(plan_valid == 1'b1, {tag, " valid"}, plan_valid, 1);
        check(plan_kind == kind[1:0], {tag, " kind"}, plan_kind, kind);
        check(plan_cs == cs[CS_W-1:0] && plan_bank == bank[BANK_W-1:0] &&
              plan_row == row[ROW_W-1:0] && plan_write == wr,
              {tag, " fields"}, plan_row, row);
    endtask

    task automatic accept();
        plan_ready = 1'b1;
        @(negedge clk);
        plan_ready = 1'b0;
    endtask

    task automatic step(input int cs, input int bank, input int row, input bit wr,
                        input int kind, input string tag);
        issue(cs, bank, row, wr);
        expect_plan(kind, cs, bank, row, wr, tag);
        accept();
    endtask

    task automatic t_reset();
        check(plan_valid == 1'b0, "R1 reset plan_valid", plan_valid, 0);
        check(req_ready == 1'b1, "R1 reset req_ready", req_ready, 1);
        step(0, 0, 5, 1'b0, 1, "R1 first access activates");
        check(req_ready == 1'b1, "R2 ready after accept", req_ready, 1);
    endtask

    task automatic t_hits();
        step(0, 0, 5, 1'b1, 0, "R6 open bank access");
        step(0, 1, 5, 1'b0, 1, "R5 inactive bank activate");
        step(0, 1, 5, 1'b1, 0, "R6 second bank now open");
        step(0, 0, 5, 1'b0, 0, "R7 first bank kept active");
        step(0, 3, 5, 1'b0, 1, "R7 untouched bank still closed");
    endtask

    task automatic t_miss();
        step(0, 2, 9, 1'b1, 2, "R4 row miss precharge");
        step(0, 0, 9, 1'b0, 1, "R8 old bank cleared");
        step(0, 2, 9, 1'b0, 0, "R8 addressed bank open");
        step(0, 2, 5, 1'b0, 2, "R4 miss back to old row");
    endtask

    task automatic t_regions();
        step(1, 2, 9, 1'b0, 1, "R10 other region closed");
        step(0, 2, 5, 1'b1, 0, "R10 region 0 row kept");
        step(1, 2, 9, 1'b0, 0, "R10 region 1 row kept");
    endtask

    task automatic t_hold_and_refresh();
        issue(0, 2, 5, 1'b0);
        expect_plan(0, 0, 2, 5, 1'b0, "R6 pending access");
        check(req_ready == 1'b0, "R2 busy while pending", req_ready, 0);
        // A request pulse while busy must be dropped.
        req_cs = 2'd3; req_bank = 2'd1; req_row = 13'd77; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        expect_plan(0, 0, 2, 5, 1'b0, "R3 plan held");
        check(plan_cs == 2'd0, "R2 busy request ignored", plan_cs, 0);
        refresh_start = 1'b1;
        @(negedge clk);
        refresh_start = 1'b0;
        expect_plan(1, 0, 2, 5, 1'b0, "R9 pending plan demoted");
        accept();
        check(plan_valid == 1'b0, "R2 busy request not queued", plan_valid, 0);
        step(0, 2, 5, 1'b0, 0, "R9 reopened bank");
        step(1, 2, 9, 1'b0, 1, "R9 region 1 closed");
        step(3, 1, 77, 1'b0, 1, "R2 region 3 never opened");
    endtask

    task automatic t_refresh_idle();
        @(negedge clk);
        refresh_start = 1'b1;
        @(negedge clk);
        refresh_start = 1'b0;
        step(0, 2, 5, 1'b0, 1, "R9 refresh closes region 0");
        step(0, 2, 6, 1'b0, 2, "R4 after reopen miss");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hits();
        t_miss();
        t_regions();
        t_hold_and_refresh();
        t_refresh_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "watchdog", 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule